// File: doc/BRIEF.md
# Interrupt enable flip-flop controller

This block holds the two interrupt enable bits of an 8-bit processor core. One bit, the gate, decides whether a maskable interrupt request reaches the sequencer. The other, the saved copy, is the only one software can observe, through the parity/overflow flag, when the vector-base or refresh register is copied into the accumulator. The sequencer drives single-cycle pulses into the block: enable, disable, non-maskable interrupt taken, maskable interrupt taken, and return from the non-maskable handler.

Keeping the bits apart lets a non-maskable handler run with maskable interrupts blocked while the earlier enable state is kept. The return from that handler, or a read of the saved copy, restores that state. After an enable, maskable requests stay blocked until a set number of further instructions (default one) has completed, so the instruction after the enable always runs before any interrupt is taken. Mode selection, vector fetch and the stack push belong to other blocks.

Top module: `irq_enable_ctrl`

## Requirements
- R1: An enable pulse (`en_pulse`), when no stronger pulse is present, sets both the gate and the saved copy on the next clock edge.
- R2: A disable pulse (`dis_pulse`), when no stronger pulse is present, clears both bits on the next clock edge.
- R3: A non-maskable acceptance pulse (`nmi_take`) clears the gate and leaves the saved copy as it was.
- R4: A maskable acceptance pulse (`irq_take`), without `nmi_take`, clears both bits.
- R5: A return-from-NMI pulse (`nmi_ret`), when it is the only pulse, copies the saved copy into the gate.
- R6: `irq_grant` is high only while `irq_req` is high, the gate is set, no post-enable hold is running and `nmi_take` is low in the same cycle.
- R7: After an enable, `irq_grant` stays low until HOLD_INSNS (default 1) `insn_done` pulses have arrived after the enable edge. A new enable restarts the count.
- R8: `pv_copy` equals the saved copy while `ir_to_acc` is high and is 0 while it is low.
- R9: Pulses arriving in the same cycle resolve in this order, highest first: `nmi_take`, `irq_take`, `dis_pulse`, `en_pulse`, `nmi_ret`. Only the highest one acts.
- R10: Reset (active-low `rst_n`, asynchronous) clears both bits and the hold count, so `irq_grant` and `pv_copy` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pulse | input | 1 | Enable-interrupts instruction completed |
| dis_pulse | input | 1 | Disable-interrupts instruction completed |
| nmi_take | input | 1 | Non-maskable interrupt accepted this cycle |
| irq_take | input | 1 | Maskable interrupt accepted this cycle |
| nmi_ret | input | 1 | Return-from-NMI instruction completed |
| insn_done | input | 1 | Any instruction completed |
| irq_req | input | 1 | Pending maskable interrupt request |
| ir_to_acc | input | 1 | Vector-base or refresh register being moved to the accumulator |
| irq_grant | output | 1 | Maskable request allowed through |
| pv_copy | output | 1 | Value for the parity/overflow flag |

## Verification
The assertions check on every cycle that each single pulse moves the two bits as required, and that a grant never appears without the gate set or while a non-maskable acceptance is present. They also check that a grant never follows an enable directly and that the flag value after an enable is 1. Only the bench scenarios show the whole pulse-by-pulse history: how the saved copy comes back through a return from the handler, how the post-enable hold ends on the right instruction, how simultaneous pulses rank against each other, and what a reset in the middle of a run does.

// File: rtl/irq_enable_pkg.sv
package irq_enable_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_NMI,
        CMD_ACK,
        CMD_OFF,
        CMD_ON,
        CMD_RESTORE
    } cmd_e;

    typedef struct packed {
        logic gate;
        logic saved;
    } flops_t;

endpackage

// File: rtl/irq_cmd_arb.sv
module irq_cmd_arb
    import irq_enable_pkg::*;
(
    input  logic en_pulse,
    input  logic dis_pulse,
    input  logic nmi_take,
    input  logic irq_take,
    input  logic nmi_ret,
    output cmd_e cmd
);

    // Fixed priority: non-maskable acceptance dominates everything.
    always_comb begin
        if (nmi_take) begin
            cmd = CMD_NMI;
        end else if (irq_take) begin
            cmd = CMD_ACK;
        end else if (dis_pulse) begin
            cmd = CMD_OFF;
        end else if (en_pulse) begin
            cmd = CMD_ON;
        end else if (nmi_ret) begin
            cmd = CMD_RESTORE;
        end else begin
            cmd = CMD_IDLE;
        end
    end

endmodule

// File: rtl/irq_hold_cnt.sv
module irq_hold_cnt
    import irq_enable_pkg::*;
#(
    parameter int unsigned HOLD_INSNS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    input  logic insn_done,
    output logic hold_busy
);

    generate
        if (HOLD_INSNS == 0) begin : g_none
            assign hold_busy = 1'b0;
        end else begin : g_cnt
            localparam int unsigned CW = $clog2(HOLD_INSNS + 1);
            localparam logic [CW-1:0] LOAD = CW'(HOLD_INSNS);

            logic [CW-1:0] cnt_d;
            logic [CW-1:0] cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (cmd == CMD_ON) begin
                    cnt_d = LOAD;
                end else if (cmd == CMD_OFF || cmd == CMD_ACK) begin
                    cnt_d = '0;
                end else if (insn_done && cnt_q != '0) begin
                    cnt_d = cnt_q - CW'(1);
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign hold_busy = (cnt_q != '0);
        end
    endgenerate

endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl
    import irq_enable_pkg::*;
#(
    parameter int unsigned HOLD_INSNS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_pulse,
    input  logic dis_pulse,
    input  logic nmi_take,
    input  logic irq_take,
    input  logic nmi_ret,
    input  logic insn_done,
    input  logic irq_req,
    input  logic ir_to_acc,
    output logic irq_grant,
    output logic pv_copy
);

    cmd_e   cmd;
    flops_t flops_d;
    flops_t flops_q;
    logic   hold_busy;
    logic   gate_q;
    logic   saved_q;

    irq_cmd_arb u_arb (
        .en_pulse  (en_pulse),
        .dis_pulse (dis_pulse),
        .nmi_take  (nmi_take),
        .irq_take  (irq_take),
        .nmi_ret   (nmi_ret),
        .cmd       (cmd)
    );

    irq_hold_cnt #(
        .HOLD_INSNS (HOLD_INSNS)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .insn_done (insn_done),
        .hold_busy (hold_busy)
    );

    always_comb begin
        flops_d = flops_q;
        case (cmd)
            CMD_NMI:     flops_d.gate = 1'b0;
            CMD_ACK,
            CMD_OFF:     flops_d = '{gate: 1'b0, saved: 1'b0};
            CMD_ON:      flops_d = '{gate: 1'b1, saved: 1'b1};
            CMD_RESTORE: flops_d.gate = flops_q.saved;
            default:     flops_d = flops_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flops_q <= '{gate: 1'b0, saved: 1'b0};
        end else begin
            flops_q <= flops_d;
        end
    end

    assign gate_q    = flops_q.gate;
    assign saved_q   = flops_q.saved;
    assign irq_grant = irq_req & gate_q & ~hold_busy & ~nmi_take;
    assign pv_copy   = ir_to_acc & saved_q;

endmodule

// File: rtl/irq_enable_chk.sv
module irq_enable_chk (
    input logic clk,
    input logic rst_n,
    input logic en_pulse,
    input logic dis_pulse,
    input logic nmi_take,
    input logic irq_take,
    input logic nmi_ret,
    input logic irq_req,
    input logic ir_to_acc,
    input logic irq_grant,
    input logic pv_copy,
    input logic gate_q,
    input logic saved_q
);

    logic above_dis;
    logic above_en;
    logic only_ret;

    assign above_dis = nmi_take | irq_take;
    assign above_en  = above_dis | dis_pulse;
    assign only_ret  = nmi_ret & ~above_en & ~en_pulse;

    assert_enable_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_pulse && !above_en) |=> (gate_q && saved_q));

    assert_disable_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_pulse && !above_dis) |=> (!gate_q && !saved_q));

    assert_nmi_keeps_saved_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_take |=> (!gate_q && saved_q == $past(saved_q)));

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !nmi_take) |=> (!gate_q && !saved_q));

    assert_restore_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        only_ret |=> (gate_q == $past(saved_q)));

    assert_grant_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_grant |-> (irq_req && gate_q && !nmi_take));

    assert_hold_after_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_pulse && !above_en) |=> !irq_grant);

    assert_pv_low_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_to_acc |-> !pv_copy);

    assert_pv_after_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_pulse && !above_en) |=> (!ir_to_acc || pv_copy));

endmodule

bind irq_enable_ctrl irq_enable_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_pulse  (en_pulse),
    .dis_pulse (dis_pulse),
    .nmi_take  (nmi_take),
    .irq_take  (irq_take),
    .nmi_ret   (nmi_ret),
    .irq_req   (irq_req),
    .ir_to_acc (ir_to_acc),
    .irq_grant (irq_grant),
    .pv_copy   (pv_copy),
    .gate_q    (gate_q),
    .saved_q   (saved_q)
);

// File: tb/irq_enable_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_enable_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n;
    logic en_pulse, dis_pulse, nmi_take, irq_take, nmi_ret, insn_done;
    logic irq_req, ir_to_acc;
    logic irq_grant, pv_copy;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    irq_enable_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_pulse  (en_pulse),
        .dis_pulse (dis_pulse),
        .nmi_take  (nmi_take),
        .irq_take  (irq_take),
        .nmi_ret   (nmi_ret),
        .insn_done (insn_done),
        .irq_req   (irq_req),
        .ir_to_acc (ir_to_acc),
        .irq_grant (irq_grant),
        .pv_copy   (pv_copy)
    );

    // [7:2] stimulus {en, dis, nmi, ack, ret, done}; [1:0] expected {grant, pv}
    // sampled in the following cycle with irq_req=1 and ir_to_acc=1.
    localparam int NV = 21;
    localparam logic [7:0] VEC [NV] = '{
        8'b000000_00, 8'b100000_01, 8'b000001_11, 8'b001000_01,
        8'b000010_11, 8'b001000_01, 8'b010000_00, 8'b000010_00,
        8'b100000_01, 8'b100001_01, 8'b000001_11, 8'b000100_00,
        8'b100000_01, 8'b000001_11, 8'b001100_01, 8'b000010_11,
        8'b110000_00, 8'b100010_01, 8'b000001_11, 8'b010100_00,
        8'b101000_00
    };

    function automatic string row_tag(int i);
        case (i)
            0:               return "R10 idle";
            1, 8, 12:        return "R1 enable";
            2, 10, 13, 18:   return "R7 hold release";
            3, 5:            return "R3 nmi";
            4:               return "R5 restore";
            6:               return "R2 disable";
            7:               return "R5 restore of zero";
            9:               return "R7 hold restart";
            11:              return "R4 ack";
            default:         return "R9 priority";
        endcase
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic idle();
        {en_pulse, dis_pulse, nmi_take, irq_take, nmi_ret, insn_done} = '0;
        irq_req   = 1'b0;
        ir_to_acc = 1'b0;
    endtask

    task automatic pulse(logic [5:0] s);
        @(negedge clk);
        idle();
        {en_pulse, dis_pulse, nmi_take, irq_take, nmi_ret, insn_done} = s;
        @(negedge clk);
        idle();
    endtask

    task automatic probe(string tag, logic eg, logic ep);
        irq_req   = 1'b1;
        ir_to_acc = 1'b1;
        #1;
        chk({tag, " grant"}, irq_grant, eg);
        chk({tag, " pv"}, pv_copy, ep);
    endtask

    initial begin
        rst_n = 1'b0;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        probe("R10 reset", 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            pulse(VEC[i][7:2]);
            probe(row_tag(i), VEC[i][1], VEC[i][0]);
        end

        // R6/R8: same-cycle nmi blocks grant; pv is 0 while ir_to_acc is low
        pulse(6'b100000);
        pulse(6'b000001);
        irq_req = 1'b1; nmi_take = 1'b1; ir_to_acc = 1'b0;
        #1;
        chk("R6 nmi same cycle", irq_grant, 1'b0);
        chk("R8 pv without read", pv_copy, 1'b0);
        @(negedge clk);
        idle();
        probe("R3 after blocked grant", 1'b0, 1'b1);

        // R6: request low gives no grant with gate set
        pulse(6'b000010);
        irq_req = 1'b0; #1;
        chk("R6 no request", irq_grant, 1'b0);
        irq_req = 1'b1; #1;
        chk("R6 request", irq_grant, 1'b1);

        // R7: idle cycles without insn_done keep the hold
        pulse(6'b100000);
        repeat (3) @(negedge clk);
        probe("R7 hold without insn", 1'b0, 1'b1);
        pulse(6'b000001);
        probe("R7 hold after insn", 1'b1, 1'b1);

        // R10: reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        probe("R10 async reset", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        probe("R10 after release", 1'b0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
            $finish;
        end
    end

endmodule